// File: doc/BRIEF.md
# NAND Flash Bus Sequencer

This block lets synchronous logic drive an asynchronous 8-bit NAND flash bus. A user port accepts one request at a time through a valid/ready handshake. Each request carries an operation code and a byte. The sequencer turns the request into one bus cycle, or into a burst of read cycles. It generates the chip-select, command-latch, address-latch, write-strobe, read-strobe and write-protect lines and an 8-bit IO bus with an output enable. Every pulse width and the read sampling point are counted in clock cycles and set by parameters.

A command request can ask the sequencer to wait for the device to finish an internal operation. In that case it deselects the device and watches the open-drain ready/busy line through a two-flop synchroniser. It waits for the line to go low and then high again. If the device takes too long, a timeout flag is raised. Write protection is lifted only while the user marks requests as part of a modify sequence. The IO bus is split into `ioOut`, `ioIn` and `ioOe`, and the pad tristate sits outside the block.

Top module: `nand_bus_seq`

## Requirements
- R1: After reset: `ceN`, `weN` and `reN` are high. `cle`, `ale`, `ioOe`, `busy`, `rdValid` and `timeoutErr` are low. `reqReady` is high. The modify marker is cleared.
- R2: Operation codes: 0 is command, 1 is address, 2 is write data and 3 is read. A command cycle drives `cle`=1 and `ale`=0. An address cycle drives `ale`=1 and `cle`=0. A write-data cycle drives both low. In each of these write cycles the request byte is on `ioOut` with `ioOe`=1 at the rising edge of `weN`, and `ceN` is low.
- R3: In a write cycle, `weN` is low for exactly WE_LO cycles and then high for WE_HI cycles with `ceN` still low. `cle`, `ale` and `ioOut` do not change across the rising edge of `weN`.
- R4: A read request with payload n produces n+1 pulses on `reN`, with no re-addressing between them. Each pulse is low for RE_LO cycles and is followed by RE_HI high cycles with `ceN` low. `ioOe` is low whenever `reN` is low.
- R5: Each read byte is taken from `ioIn` at the clock edge RD_SAMPLE cycles after `reN` falls. It appears on `rdData` with a one-cycle `rdValid` pulse in the following cycle, in bus order.
- R6: `reqReady` is high only when the sequencer is idle, and a request is taken on a clock edge where both `reqValid` and `reqReady` are high. `busy` is the inverse of `reqReady`.
- R7: `wpN` is high whenever `protEn` is low. When `protEn` is high, `wpN` follows the `reqModify` bit of the last accepted request, and the value holds after that operation ends.
- R8: A command request with `reqWait` set deselects the device (`ceN` high) after its write cycle. The sequencer stays busy until the synchronised `rbN` has been seen low and then high. It returns to idle on the third clock edge after `rbN` rises.
- R9: If the wait of R8 lasts TIMEOUT cycles, `timeoutErr` is set and the sequencer returns to idle. The flag clears when the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Sequencer can accept a request |
| reqOp | input | 2 | Operation code (0 cmd, 1 addr, 2 write data, 3 read) |
| reqData | input | 8 | Byte to write; for reads, byte count minus one |
| reqWait | input | 1 | After a command, wait for the device ready/busy cycle |
| reqModify | input | 1 | Request belongs to a program/erase sequence |
| busy | output | 1 | Operation in progress |
| rdValid | output | 1 | One-cycle strobe for `rdData` |
| rdData | output | 8 | Byte read from the bus |
| timeoutErr | output | 1 | Ready/busy wait timed out |
| protEn | input | 1 | Write protection enabled |
| ceN | output | 1 | Device select, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| weN | output | 1 | Write strobe, active low |
| reN | output | 1 | Read strobe, active low |
| wpN | output | 1 | Write protect, active low |
| ioOut | output | 8 | IO bus output value |
| ioIn | input | 8 | IO bus input value |
| ioOe | output | 1 | IO bus output enable |
| rbN | input | 1 | Ready/busy from the device, low = busy |

## Verification
A request is accepted at the edge where `reqReady` is seen high. The bus strobes change on that same edge. Pulse widths are therefore measured as runs of `weN`/`reN` levels, sampled on falling clock edges. A bench model of the device presents a garbage byte when `reN` falls. It presents the real byte only just before the edge RD_SAMPLE cycles later, so a sample taken one cycle early is caught. The scoreboard expects `rdValid` one cycle after that edge. For the ready/busy wait, idle must return on the third edge after `rbN` rises: two synchroniser flops and one state update. The timeout wait must last exactly TIMEOUT cycles with `ceN` high. The bench checks both at those exact cycles.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    OP_CMD   = 2'd0,
    OP_ADDR  = 2'd1,
    OP_WDATA = 2'd2,
    OP_RDATA = 2'd3
  } nand_op_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeWrite;  // latch request byte for the IO bus
    logic takeMod;    // latch modify marker
    logic modVal;     // value of the modify marker
    logic driveIo;    // enable IO output drivers
    logic sample;     // capture ioIn this edge
  } dp_ctrl_t;

endpackage

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int WE_LO     = 2,
  parameter int WE_HI     = 2,
  parameter int RE_LO     = 3,
  parameter int RE_HI     = 2,
  parameter int RD_SAMPLE = 2,
  parameter int TIMEOUT   = 4096
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  nand_op_e reqOp,
  input  logic [7:0] reqData,
  input  logic     reqWait,
  input  logic     reqModify,
  input  logic     rbReady,
  output logic     reqReady,
  output logic     busy,
  output logic     timeoutErr,
  output logic     ceN,
  output logic     cle,
  output logic     ale,
  output logic     weN,
  output logic     reN,
  output dp_ctrl_t ctl
);

  localparam int PH_A   = (WE_LO > WE_HI) ? WE_LO : WE_HI;
  localparam int PH_B   = (RE_LO > RE_HI) ? RE_LO : RE_HI;
  localparam int PH_MAX = (PH_A > PH_B) ? PH_A : PH_B;
  localparam int CNT_W  = $clog2(PH_MAX + 1);
  localparam int TO_W   = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] WL_END  = CNT_W'(WE_LO - 1);
  localparam logic [CNT_W-1:0] WH_END  = CNT_W'(WE_HI - 1);
  localparam logic [CNT_W-1:0] RL_END  = CNT_W'(RE_LO - 1);
  localparam logic [CNT_W-1:0] RH_END  = CNT_W'(RE_HI - 1);
  localparam logic [CNT_W-1:0] SMP_END = CNT_W'(RD_SAMPLE - 1);
  localparam logic [TO_W-1:0]  TO_END  = TO_W'(TIMEOUT - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WLO, S_WHI, S_RLO, S_RHI, S_WTLO, S_WTHI
  } state_e;

  state_e          state;
  logic [CNT_W-1:0] phCnt;
  logic [TO_W-1:0]  toCnt;
  logic [8:0]       remain;
  nand_op_e         opReg;
  logic             waitReg;
  logic             errReg;
  logic             accept;

  assign accept = reqValid && (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      phCnt   <= '0;
      toCnt   <= '0;
      remain  <= '0;
      opReg   <= OP_CMD;
      waitReg <= 1'b0;
      errReg  <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          opReg   <= reqOp;
          waitReg <= reqWait;
          errReg  <= 1'b0;
          phCnt   <= '0;
          if (reqOp == OP_RDATA) begin
            remain <= {1'b0, reqData} + 9'd1;
            state  <= S_RLO;
          end else begin
            state  <= S_WLO;
          end
        end
        S_WLO: if (phCnt == WL_END) begin
          phCnt <= '0;
          state <= S_WHI;
        end else phCnt <= phCnt + 1'b1;
        S_WHI: if (phCnt == WH_END) begin
          phCnt <= '0;
          toCnt <= '0;
          state <= (opReg == OP_CMD && waitReg) ? S_WTLO : S_IDLE;
        end else phCnt <= phCnt + 1'b1;
        S_RLO: if (phCnt == RL_END) begin
          phCnt <= '0;
          state <= S_RHI;
        end else phCnt <= phCnt + 1'b1;
        S_RHI: if (phCnt == RH_END) begin
          phCnt <= '0;
          if (remain == 9'd1) state <= S_IDLE;
          else begin
            remain <= remain - 9'd1;
            state  <= S_RLO;
          end
        end else phCnt <= phCnt + 1'b1;
        S_WTLO, S_WTHI: if (toCnt == TO_END) begin
          errReg <= 1'b1;
          state  <= S_IDLE;
        end else begin
          toCnt <= toCnt + 1'b1;
          if (state == S_WTLO && !rbReady) state <= S_WTHI;
          if (state == S_WTHI && rbReady)  state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady      = (state == S_IDLE);
    busy          = !reqReady;
    timeoutErr    = errReg;
    ceN           = !(state inside {S_WLO, S_WHI, S_RLO, S_RHI});
    cle           = (state inside {S_WLO, S_WHI}) && (opReg == OP_CMD);
    ale           = (state inside {S_WLO, S_WHI}) && (opReg == OP_ADDR);
    weN           = (state != S_WLO);
    reN           = (state != S_RLO);
    ctl.takeWrite = accept && (reqOp != OP_RDATA);
    ctl.takeMod   = accept;
    ctl.modVal    = reqModify;
    ctl.driveIo   = (state inside {S_WLO, S_WHI});
    ctl.sample    = (state == S_RLO) && (phCnt == SMP_END);
  end

endmodule

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
  import nand_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dp_ctrl_t   ctl,
  input  logic [7:0] reqData,
  input  logic [7:0] ioIn,
  input  logic       rbN,
  input  logic       protEn,
  output logic [7:0] ioOut,
  output logic       ioOe,
  output logic [7:0] rdData,
  output logic       rdValid,
  output logic       wpN,
  output logic       rbReady
);

  logic [7:0] wrByte;
  logic [7:0] rdReg;
  logic       rdVld;
  logic       modReg;
  logic       rbMeta;
  logic       rbSync;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrByte <= '0;
      rdReg  <= '0;
      rdVld  <= 1'b0;
      modReg <= 1'b0;
      rbMeta <= 1'b1;
      rbSync <= 1'b1;
    end else begin
      rbMeta <= rbN;
      rbSync <= rbMeta;
      rdVld  <= ctl.sample;
      if (ctl.sample)    rdReg  <= ioIn;
      if (ctl.takeWrite) wrByte <= reqData;
      if (ctl.takeMod)   modReg <= ctl.modVal;
    end
  end

  assign ioOut   = wrByte;
  assign ioOe    = ctl.driveIo;
  assign rdData  = rdReg;
  assign rdValid = rdVld;
  assign wpN     = !protEn || modReg;
  assign rbReady = rbSync;

endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
  import nand_seq_pkg::*;
#(
  parameter int WE_LO     = 2,
  parameter int WE_HI     = 2,
  parameter int RE_LO     = 3,
  parameter int RE_HI     = 2,
  parameter int RD_SAMPLE = 2,
  parameter int TIMEOUT   = 4096
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic [1:0] reqOp,
  input  logic [7:0] reqData,
  input  logic       reqWait,
  input  logic       reqModify,
  output logic       busy,
  output logic       rdValid,
  output logic [7:0] rdData,
  output logic       timeoutErr,
  input  logic       protEn,
  output logic       ceN,
  output logic       cle,
  output logic       ale,
  output logic       weN,
  output logic       reN,
  output logic       wpN,
  output logic [7:0] ioOut,
  input  logic [7:0] ioIn,
  output logic       ioOe,
  input  logic       rbN
);

  dp_ctrl_t ctl;
  logic     rbReady;
  nand_op_e opIn;

  assign opIn = nand_op_e'(reqOp);

  nand_seq_ctrl #(
    .WE_LO(WE_LO), .WE_HI(WE_HI), .RE_LO(RE_LO), .RE_HI(RE_HI),
    .RD_SAMPLE(RD_SAMPLE), .TIMEOUT(TIMEOUT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(opIn),
    .reqData(reqData), .reqWait(reqWait), .reqModify(reqModify),
    .rbReady(rbReady), .reqReady(reqReady), .busy(busy),
    .timeoutErr(timeoutErr), .ceN(ceN), .cle(cle), .ale(ale),
    .weN(weN), .reN(reN), .ctl(ctl)
  );

  nand_seq_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqData(reqData), .ioIn(ioIn),
    .rbN(rbN), .protEn(protEn), .ioOut(ioOut), .ioOe(ioOe),
    .rdData(rdData), .rdValid(rdValid), .wpN(wpN), .rbReady(rbReady)
  );

endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqReady,
  input logic       busy,
  input logic       rdValid,
  input logic       timeoutErr,
  input logic       protEn,
  input logic       ceN,
  input logic       cle,
  input logic       ale,
  input logic       weN,
  input logic       reN,
  input logic       wpN,
  input logic [7:0] ioOut,
  input logic       ioOe
);

  // R2: command and address latches never both active
  p_latch_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(cle && ale));

  // R3: latch-relevant lines stable across the write strobe rise
  p_we_rise_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(weN) |-> ($stable(cle) && $stable(ale) && $stable(ioOut) && ioOe && !ceN));

  // R4: drivers released whenever the read strobe is active
  p_no_drive_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    !reN |-> (!ioOe && !ceN && weN));

  // R5: a read byte follows a cycle with the read strobe active
  p_rdvalid_after_re_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(!reN));

  // R6: idle means all strobes quiet
  p_ready_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (ceN && weN && reN && !ioOe && !busy));

  // R7: no protection when disabled
  p_wp_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    !protEn |-> wpN);

  // R8: deselected while busy means waiting, not accepting
  p_wait_deselect_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ceN) |-> (!reqReady && weN && reN));

  // R9: timeout flag rises only as the sequencer goes idle
  p_timeout_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> reqReady);

endmodule

bind nand_bus_seq nand_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .busy(busy),
  .rdValid(rdValid), .timeoutErr(timeoutErr), .protEn(protEn),
  .ceN(ceN), .cle(cle), .ale(ale), .weN(weN), .reN(reN), .wpN(wpN),
  .ioOut(ioOut), .ioOe(ioOe)
);

// File: tb/nand_bus_seq_bench.sv
module nand_bus_seq_bench;
  import nand_seq_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WE_LO = 2, WE_HI = 1, RE_LO = 3, RE_HI = 2;
  localparam int RD_SAMPLE = 2, TIMEOUT = 20;

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWait = 0, reqModify = 0, protEn = 1, rbN = 1;
  logic [1:0] reqOp = 0;
  logic [7:0] reqData = 0, ioIn = 0;
  logic reqReady, busy, rdValid, timeoutErr, ceN, cle, ale, weN, reN, wpN, ioOe;
  logic [7:0] rdData, ioOut;

  int checks = 0, fails = 0;
  bit started = 0, done = 0;
  logic [9:0] expWr[$];
  logic [7:0] expRd[$];
  logic [7:0] colPtr = 0, expCol = 0;
  int rdPulses = 0, rdSeen = 0, waitCnt = 0;
  int weLo = 0, weHi = 0, reLo = 0, reHi = 0;
  bit weRun = 0, reRun = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_bus_seq #(.WE_LO(WE_LO), .WE_HI(WE_HI), .RE_LO(RE_LO), .RE_HI(RE_HI),
                 .RD_SAMPLE(RD_SAMPLE), .TIMEOUT(TIMEOUT)) u_nand_bus_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqData(reqData), .reqWait(reqWait), .reqModify(reqModify),
    .busy(busy), .rdValid(rdValid), .rdData(rdData), .timeoutErr(timeoutErr),
    .protEn(protEn), .ceN(ceN), .cle(cle), .ale(ale), .weN(weN), .reN(reN),
    .wpN(wpN), .ioOut(ioOut), .ioIn(ioIn), .ioOe(ioOe), .rbN(rbN));

  function automatic logic [7:0] memByte(logic [7:0] c);
    return c * 8'd37 + 8'h1B;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic sendReq(nand_op_e op, logic [7:0] d, bit w, bit m);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1; reqOp = op; reqData = d; reqWait = w; reqModify = m;
    if (op == OP_RDATA) begin
      for (int i = 0; i <= d; i++) begin expRd.push_back(memByte(expCol)); expCol++; end
    end else
      expWr.push_back({op == OP_CMD, op == OP_ADDR, d});
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
    chk(busy && !reqReady, "R6", "busy after accept", {busy, reqReady}, 2'b10);
  endtask

  task automatic waitIdle();
    while (!reqReady) @(negedge clk);
  endtask

  // device model: write capture
  always @(posedge weN) if (started) begin
    if (expWr.size() == 0) chk(0, "R2", "unexpected write", {cle, ale, ioOut}, 0);
    else begin
      logic [9:0] e;
      e = expWr.pop_front();
      chk({cle, ale, ioOut} == e, "R2", "latched cycle", {cle, ale, ioOut}, e);
      chk(!ceN && ioOe, "R2", "ce/oe at latch", {ceN, ioOe}, 2'b01);
    end
  end

  // device model: read data valid only after the access delay
  always @(negedge reN) if (started) begin
    rdPulses++;
    ioIn = 8'hEE;
    repeat (RD_SAMPLE - 1) @(posedge clk);
    #1 ioIn = memByte(colPtr);
  end
  always @(posedge reN) if (started) colPtr++;

  // scoreboard monitor and pulse-width monitor
  always @(negedge clk) if (started) begin
    if (rdValid) begin
      rdSeen++;
      if (expRd.size() == 0) chk(0, "R5", "unexpected read byte", rdData, 0);
      else begin
        logic [7:0] e;
        e = expRd.pop_front();
        chk(rdData == e, "R5", "read byte", rdData, e);
      end
    end
    if (busy && ceN) waitCnt++;
    // write strobe widths
    if (!weN) weLo++;
    else if (weLo != 0) begin
      chk(weLo == WE_LO, "R3", "weN low width", weLo, WE_LO);
      weLo = 0; weRun = 1; weHi = 1;
    end else if (weRun) begin
      if (ceN) begin chk(weHi == WE_HI, "R3", "weN high width", weHi, WE_HI); weRun = 0; end
      else weHi++;
    end
    // read strobe widths
    if (!reN) begin
      if (reRun) begin chk(reHi == RE_HI, "R4", "reN high width", reHi, RE_HI); reRun = 0; end
      reLo++;
      chk(!ioOe, "R4", "ioOe during read", ioOe, 0);
    end else if (reLo != 0) begin
      chk(reLo == RE_LO, "R4", "reN low width", reLo, RE_LO);
      reLo = 0; reRun = 1; reHi = 1;
    end else if (reRun) begin
      if (ceN) begin chk(reHi == RE_HI, "R4", "reN high width", reHi, RE_HI); reRun = 0; end
      else reHi++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(ceN && weN && reN, "R1", "strobes high", {ceN, weN, reN}, 3'b111);
    chk(!cle && !ale && !ioOe, "R1", "latches/oe low", {cle, ale, ioOe}, 0);
    chk(reqReady && !busy && !rdValid && !timeoutErr, "R1", "status",
        {reqReady, busy, rdValid, timeoutErr}, 4'b1000);
    rstN = 1;
    started = 1;
    @(negedge clk);
    chk(!wpN, "R1", "modify marker cleared (protEn=1)", wpN, 0);

    // R2/R3: command, address, data cycles
    sendReq(OP_CMD, 8'h00, 0, 0);
    sendReq(OP_ADDR, 8'h12, 0, 0);
    sendReq(OP_ADDR, 8'h34, 0, 0);
    sendReq(OP_WDATA, 8'h5A, 0, 0);
    waitIdle();

    // R4/R5: burst of 4 then a single byte, column continues
    sendReq(OP_RDATA, 8'd3, 0, 0);
    sendReq(OP_RDATA, 8'd0, 0, 0);
    waitIdle();
    repeat (3) @(negedge clk);
    chk(rdPulses == 5, "R4", "read pulse count", rdPulses, 5);
    chk(rdSeen == 5, "R5", "read byte count", rdSeen, 5);

    // R7: write protect follows modify marker
    sendReq(OP_CMD, 8'h80, 0, 1);
    chk(wpN, "R7", "wpN high in modify", wpN, 1);
    waitIdle(); @(negedge clk);
    chk(wpN, "R7", "wpN holds after op", wpN, 1);
    sendReq(OP_WDATA, 8'hC3, 0, 0);
    chk(!wpN, "R7", "wpN low when not modify", wpN, 0);
    waitIdle();
    protEn = 0; @(negedge clk);
    chk(wpN, "R7", "wpN high when protection off", wpN, 1);
    protEn = 1;

    // R8: wait for ready/busy low then high, device deselected
    sendReq(OP_CMD, 8'h10, 1, 1);
    while (!(busy && ceN)) @(negedge clk);
    chk(!reqReady, "R8", "not ready in wait", reqReady, 0);
    repeat (3) @(negedge clk);
    rbN = 0;
    repeat (5) @(negedge clk);
    chk(busy && ceN, "R8", "still waiting with ce high", {busy, ceN}, 2'b11);
    rbN = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(!reqReady, "R8", "not idle before sync", reqReady, 0);
    @(negedge clk);
    chk(reqReady && !timeoutErr, "R8", "idle after sync", {reqReady, timeoutErr}, 2'b10);

    // R9: timeout when ready/busy never toggles
    waitCnt = 0;
    sendReq(OP_CMD, 8'h60, 1, 0);
    waitIdle();
    chk(timeoutErr, "R9", "timeout flag", timeoutErr, 1);
    chk(waitCnt == TIMEOUT, "R9", "wait length", waitCnt, TIMEOUT);
    sendReq(OP_WDATA, 8'h99, 0, 0);
    chk(!timeoutErr, "R9", "flag cleared by next request", timeoutErr, 0);
    waitIdle();
    repeat (4) @(negedge clk);

    chk(expWr.size() == 0, "R2", "write queue drained", expWr.size(), 0);
    chk(expRd.size() == 0, "R5", "read queue drained", expRd.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule